// File: doc/BRIEF.md
# Dual-Path Staircase Sine Tone Generator

The block produces dual-tone dialling signals and simple melodies from two independent tone paths, named row and column. Each path has a frequency code, a divider that emits step ticks, and a 32-step scan counter that walks a staircase sine table. Per-path enables start and stop each path. A global output enable gates the result. A mode input selects staircase sine or square wave. The registered output is the unsigned sum of the two path levels, ready for an external converter.

When a path is stopped, its divider and scan counter are held in their reset state. The scan counter then points at the table entry for the midpoint level, so every start is phase-aligned at DC. A validator rejects column codes below 4. A rejected column path is held stopped and contributes the midpoint level.

Top module: `tone_pair_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sample` reads 64, the sum of two midpoint levels.
- R2: With `row_en` and `col_en` both low, both paths are held at their reset state and `sample` is 64 one cycle later.
- R3: When a path becomes active, its first contribution is table entry 0 (level 32). Its first step follows N+1 cycles after the first enabled edge, where N is its frequency code.
- R4: An active path advances its scan index by one every N+1 clock cycles. The index wraps from 31 to 0, so one tone period is 32·(N+1) cycles.
- R5: In sine mode (`square` low), entry k is 32+A(k) for k in 0..8, 32+A(16-k) for k in 9..16, 32-A(k-16) for k in 17..24, and 32-A(32-k) for k in 25..31. Here A(0..8) = 0,6,12,17,22,26,29,30,31.
- R6: In square mode (`square` high), an active path gives 63 while its scan index is below 16 and 0 otherwise.
- R7: A column code below 4 is illegal. The column path is then held at reset and contributes 32 whatever `col_en` is. Once the code is legal, the path starts as in R3.
- R8: With `out_en` low, `sample` is 64 one cycle later, whatever else is set.
- R9: Either path may run alone. A path whose enable is low contributes 32.
- R10: A frequency code changed while a path runs takes effect only after the next step tick. The scan index is not reset.
- R11: `sample` is registered: it reflects the path states after the previous clock edge, and it never exceeds 126.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_freq | input | FREQ_W | Row path frequency code N |
| col_freq | input | FREQ_W | Column path frequency code N (legal when at least 4) |
| row_en | input | 1 | Row path enable |
| col_en | input | 1 | Column path enable |
| out_en | input | 1 | Tone output enable |
| square | input | 1 | 1 selects square wave, 0 selects staircase sine |
| sample | output | FREQ_W-independent, LVL_W+1 (7) | Unsigned sum of both path levels |

## Verification
The bench targets the timing of the first step after an enable. A divider that counted from its old code, or that started part-way, would shift every later sample by a cycle or a step. It checks that stopping and restarting both paths returns the output to exactly 64 and resumes at entry 0; a design that kept its phase would resume at a random level. The column code at 3 and at 4 is exercised: an off-by-one validator would pass or block the wrong code. A code change in mid-tone is checked against the reload point; a design that applied it at once, or cleared the scan index, would step at the wrong cycle.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int STEP_W = 5;
  localparam int LVL_W  = 6;
  localparam int MID    = 32;

  function automatic int quarter_amp(input int q);
    case (q)
      0:       return 0;
      1:       return 6;
      2:       return 12;
      3:       return 17;
      4:       return 22;
      5:       return 26;
      6:       return 29;
      7:       return 30;
      default: return 31;
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] sine_entry(input logic [STEP_W-1:0] k);
    int ki;
    int q;
    bit neg;
    ki = int'(k);
    if (ki <= 8) begin
      q = ki; neg = 1'b0;
    end else if (ki <= 16) begin
      q = 16 - ki; neg = 1'b0;
    end else if (ki <= 24) begin
      q = ki - 16; neg = 1'b1;
    end else begin
      q = 32 - ki; neg = 1'b1;
    end
    return neg ? LVL_W'(MID - quarter_amp(q)) : LVL_W'(MID + quarter_amp(q));
  endfunction
endpackage

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int FREQ_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [FREQ_W-1:0] code,
  output logic              tick
);
  logic [FREQ_W-1:0] cnt;
  logic [FREQ_W-1:0] lim_q;
  logic              run_q;
  logic [FREQ_W-1:0] target;

  assign target = run_q ? lim_q : code;
  assign tick   = run && (cnt == target);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      lim_q <= code;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (tick) begin
        cnt   <= '0;
        lim_q <= code;
      end else begin
        cnt <= cnt + 1'b1;
        if (!run_q) lim_q <= code;
      end
    end
  end

  // R4
  div_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> (!run || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/tone_wave.sv
module tone_wave
  import tone_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             square,
  output logic [LVL_W-1:0] level
);
  logic [STEP_W-1:0] scan;

  always_ff @(posedge clk) begin
    if (rst || !run) scan <= '0;
    else if (tick)   scan <= scan + 1'b1;
  end

  always_comb begin
    if (square) level = scan[STEP_W-1] ? '0 : {LVL_W{1'b1}};
    else        level = sine_entry(scan);
  end

  // R4
  scan_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick) |=> (!run || scan == $past(scan) + 1'b1));

  // R10
  scan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> (!run || $stable(scan)));
endmodule

// File: rtl/tone_path.sv
module tone_path
  import tone_pkg::*;
#(
  parameter int FREQ_W   = 8,
  parameter int MIN_CODE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [FREQ_W-1:0] code,
  input  logic              square,
  output logic [LVL_W-1:0]  level
);
  logic             legal;
  logic             run;
  logic             tick;
  logic [LVL_W-1:0] wave_lvl;

  generate
    if (MIN_CODE == 0) begin : g_any
      assign legal = 1'b1;
    end else begin : g_check
      assign legal = (code >= FREQ_W'(MIN_CODE));
    end
  endgenerate

  assign run   = en && legal;
  assign level = run ? wave_lvl : LVL_W'(MID);

  tone_divider #(.FREQ_W(FREQ_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .code (code),
    .tick (tick)
  );

  tone_wave u_wave (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .tick   (tick),
    .square (square),
    .level  (wave_lvl)
  );
endmodule

// File: rtl/tone_pair_gen.sv
module tone_pair_gen
  import tone_pkg::*;
#(
  parameter int FREQ_W  = 8,
  parameter int MIN_COL = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FREQ_W-1:0] row_freq,
  input  logic [FREQ_W-1:0] col_freq,
  input  logic              row_en,
  input  logic              col_en,
  input  logic              out_en,
  input  logic              square,
  output logic [LVL_W:0]    sample
);
  localparam int SMP_W = LVL_W + 1;
  localparam logic [SMP_W-1:0] MID_SUM = SMP_W'(2 * MID);

  logic [LVL_W-1:0] row_lvl;
  logic [LVL_W-1:0] col_lvl;

  tone_path #(.FREQ_W(FREQ_W), .MIN_CODE(0)) u_row (
    .clk    (clk),
    .rst    (rst),
    .en     (row_en),
    .code   (row_freq),
    .square (square),
    .level  (row_lvl)
  );

  tone_path #(.FREQ_W(FREQ_W), .MIN_CODE(MIN_COL)) u_col (
    .clk    (clk),
    .rst    (rst),
    .en     (col_en),
    .code   (col_freq),
    .square (square),
    .level  (col_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst || !out_en) sample <= MID_SUM;
    else                sample <= {1'b0, row_lvl} + {1'b0, col_lvl};
  end

  // R8
  mute_mid_chk: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (sample == MID_SUM));

  // R2
  idle_mid_chk: assert property (@(posedge clk) disable iff (rst)
    (!row_en && !col_en) |=> (sample == MID_SUM));

  // R7
  col_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!row_en && col_freq < FREQ_W'(MIN_COL)) |=> (sample == MID_SUM));

  // R11
  sample_range_chk: assert property (@(posedge clk) disable iff (rst)
    sample <= SMP_W'(126));
endmodule

// File: tb/tone_pair_gen_bench.sv
module tone_pair_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] row_freq = '0;
  logic [7:0] col_freq = '0;
  logic       row_en = 1'b0;
  logic       col_en = 1'b0;
  logic       out_en = 1'b0;
  logic       square = 1'b0;
  logic [6:0] sample;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tone_pair_gen u_tone_pair_gen (
    .clk(clk), .rst(rst), .row_freq(row_freq), .col_freq(col_freq),
    .row_en(row_en), .col_en(col_en), .out_en(out_en), .square(square),
    .sample(sample)
  );

  typedef struct packed {
    logic [7:0]  rf;
    logic [7:0]  cf;
    logic        ren;
    logic        cen;
    logic        oen;
    logic        sq;
    logic [15:0] k;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'd3, 8'd5, 1'b1, 1'b1, 1'b1, 1'b0, 16'd10},
    '{8'd2, 8'd0, 1'b1, 1'b0, 1'b1, 1'b0, 16'd20},
    '{8'd0, 8'd7, 1'b0, 1'b1, 1'b1, 1'b0, 16'd50},
    '{8'd5, 8'd3, 1'b1, 1'b1, 1'b1, 1'b0, 16'd40},
    '{8'd4, 8'd4, 1'b1, 1'b1, 1'b1, 1'b0, 16'd100},
    '{8'd1, 8'd9, 1'b1, 1'b1, 1'b1, 1'b1, 16'd37},
    '{8'd6, 8'd6, 1'b1, 1'b1, 1'b0, 1'b0, 16'd30},
    '{8'd0, 8'd4, 1'b1, 1'b1, 1'b1, 1'b1, 16'd70},
    '{8'd0, 8'd0, 1'b1, 1'b0, 1'b1, 1'b0, 16'd33}
  };
  localparam string VTAG [NV] = '{"R5", "R9", "R9", "R7", "R4", "R6", "R8", "R6", "R4"};

  function automatic int amp(input int q);
    case (q)
      0: return 0;  1: return 6;  2: return 12; 3: return 17;
      4: return 22; 5: return 26; 6: return 29; 7: return 30;
      default: return 31;
    endcase
  endfunction

  function automatic int ref_level(input int idx, input bit sq);
    int i;
    i = idx % 32;
    if (sq) return (i < 16) ? 63 : 0;
    if (i <= 8)  return 32 + amp(i);
    if (i <= 16) return 32 + amp(16 - i);
    if (i <= 24) return 32 - amp(i - 16);
    return 32 - amp(32 - i);
  endfunction

  // Level of one path k edges after it became active.
  function automatic int path_ref(input bit act, input int n, input bit sq, input int k);
    if (!act || k < 1) return 32;
    return ref_level((k - 1) / (n + 1), sq);
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: sample=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; row_en = 0; col_en = 0; out_en = 0; square = 0;
    row_freq = '0; col_freq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int exp;
    // R1: reset value, during reset and just after
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", int'(sample), 64);
    do_reset();
    edges(1);
    check("R1 after reset", int'(sample), 64);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      row_freq = VECS[v].rf; col_freq = VECS[v].cf;
      row_en = VECS[v].ren; col_en = VECS[v].cen;
      out_en = VECS[v].oen; square = VECS[v].sq;
      edges(int'(VECS[v].k));
      if (VECS[v].oen)
        exp = path_ref(VECS[v].ren, int'(VECS[v].rf), VECS[v].sq, int'(VECS[v].k)) +
              path_ref(VECS[v].cen && VECS[v].cf >= 4, int'(VECS[v].cf), VECS[v].sq, int'(VECS[v].k));
      else
        exp = 64;
      check(VTAG[v], int'(sample), exp);
    end

    // R2 / R3: stop both paths, then restart phase-aligned
    do_reset();
    row_freq = 8'd1; col_freq = 8'd4; row_en = 1; col_en = 1; out_en = 1;
    edges(10);
    row_en = 0; col_en = 0;
    edges(1);
    check("R2 stop", int'(sample), 64);
    edges(5);
    check("R2 held", int'(sample), 64);
    row_en = 1; col_en = 1;
    edges(1);
    check("R3 restart entry0", int'(sample), 64);
    edges(2);
    check("R3 first step", int'(sample), path_ref(1, 1, 0, 3) + path_ref(1, 4, 0, 3));

    // R10: code change mid-tone applies after next tick, no scan reset
    do_reset();
    row_freq = 8'd3; row_en = 1; out_en = 1;
    edges(4);
    row_freq = 8'd7;
    edges(5);
    check("R10 old code to reload", int'(sample), ref_level(2, 0) + 32);
    edges(7);
    check("R10 new period hold", int'(sample), ref_level(2, 0) + 32);
    edges(1);
    check("R10 new period step", int'(sample), ref_level(3, 0) + 32);

    // R7: column code boundary 3 then 4
    do_reset();
    col_freq = 8'd3; col_en = 1; out_en = 1;
    edges(20);
    check("R7 code 3 blocked", int'(sample), 64);
    col_freq = 8'd4;
    edges(12);
    check("R7 code 4 runs", int'(sample), 32 + path_ref(1, 4, 0, 12));

    // R8: mute while running, then unmute keeps phase running
    do_reset();
    row_freq = 8'd0; col_freq = 8'd4; row_en = 1; col_en = 1; out_en = 1;
    edges(6);
    out_en = 0;
    edges(1);
    check("R8 mute", int'(sample), 64);
    out_en = 1;
    edges(1);
    check("R11 unmute latency", int'(sample), path_ref(1, 0, 0, 8) + path_ref(1, 4, 0, 8));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule